// File: doc/BRIEF.md
# Paged Digital I/O Controller with Edge Interrupts

This block is a general-purpose digital I/O controller with 48 channels, grouped as six 8-bit ports behind a byte-wide register bus with a 4-bit address. Each channel has an open-drain style output. A 0 in the output latch pulls the pin low. A 1 releases the pin, so that an external source can drive it and the channel acts as an input. Port reads return the pin levels after a two-flop synchroniser.

The lower 24 channels (ports 0 to 2) can each raise an edge interrupt. Each of these channels has its own edge polarity and enable bit. A detected edge latches a per-channel identification bit, and software clears that bit explicitly. The polarity, enable and identification banks share one three-address window. A control register selects which bank that window shows. The same control register holds a lock mask that makes individual ports read-only. A pending-summary register and a single interrupt request output let software find the source quickly.

Top module: `pdio_edge_ctl`

## Requirements
- R1: After reset every output latch is 1 (all pins released), the page is 0, the lock mask is 0, and all polarity, enable and identification bits are 0. The `irq` output is low and the pending register reads 0.
- R2: Writing address 0x0 to 0x5 loads the output latch of port 0 to 5, and the latch value appears on `pin_out` at once. A read of address 0x0 to 0x5 returns the pin levels on `pin_in` for that port, delayed by two clock edges.
- R3: Writing address 0x7 loads the lock mask from bits 5:0, where bit n locks port n. While a port is locked, writes to it leave its latch unchanged, and reads of it still return the pin levels.
- R4: Address 0x7 loads the page from bits 7:6, with page 1 = polarity, page 2 = enable and page 3 = identification. Address 0x7 reads 0. Addresses 0x8 to 0xA read 0 on pages 1 and 2.
- R5: On page 0, addresses 0x8 to 0xA read 0, and writes to them change no polarity, enable or identification bit.
- R6: With page 1 selected, a write to address 0x8+n sets the polarity of interrupt port n (1 = rising edge, 0 = falling edge). With page 2 selected, a write to address 0x8+n sets the enables of interrupt port n. An edge of the wrong polarity, or an edge on a disabled channel, latches nothing.
- R7: A detected edge sets the channel's identification bit, which reads back at address 0x8+n on page 3. The bit stays set until software writes 0 to that bit position on page 3. Writing 1 to a bit position leaves it as it is.
- R8: If a new edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: Bit n of address 0x6 is 1 when any identification bit of interrupt port n is set. `irq` is high when any pending bit is set.
- R10: Channels of ports 3 to 5 never affect `irq` or the pending register.
- R11: Addresses 0xB to 0xF read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 48 | Sensed pin levels |
| pin_out | output | 48 | Output latches; 0 pulls the pin low, 1 releases it |
| irq | output | 1 | Interrupt request, OR of all pending bits |

## Verification
The embedded properties check on every cycle the rules that govern the identification bits. A bit may rise only after an enabled edge. It never falls without a clear write. A detected edge always leaves it set, even when a clear arrives in the same cycle. The properties also check that locked ports keep their latches and that page 0 writes leave the polarity and enable bits alone. Some behaviour shows only at the pins and bus, so the directed scenarios cover it: the two-edge read latency, the choice of bank made by each page value, read-as-zero addresses, polarity selection, the pending bit positions, and the behaviour of the ports that cannot interrupt.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
   typedef enum logic [1:0] {
      PG_OFF = 2'd0,
      PG_POL = 2'd1,
      PG_ENA = 2'd2,
      PG_ID  = 2'd3
   } pdio_page_e;

   localparam int PAGE_BITS = 2;
endpackage

// File: rtl/pdio_ctl_reg.sv
module pdio_ctl_reg
   import pdio_pkg::*;
#(
   parameter int NUM_PORTS = 6,
   parameter int DATA_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [DATA_W-1:0]    wdata,
   output pdio_page_e           page,
   output logic [NUM_PORTS-1:0] lock
);
   localparam int PAGE_LSB = DATA_W - PAGE_BITS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page <= PG_OFF;
         lock <= '0;
      end else if (ctl_we) begin
         page <= pdio_page_e'(wdata[PAGE_LSB +: PAGE_BITS]);
         lock <= wdata[NUM_PORTS-1:0];
      end
   end
endmodule

// File: rtl/pdio_port_latch.sv
module pdio_port_latch #(
   parameter int NUM_PORTS = 6,
   parameter int PORT_W    = 8,
   parameter int ADDR_W    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [PORT_W-1:0]           wdata,
   input  logic [NUM_PORTS-1:0]        lock,
   output logic [NUM_PORTS*PORT_W-1:0] latch
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PORT_W-1:0] q;
      logic              hit;

      assign hit = bus_wr && (bus_addr == ADDR_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '1;
         else if (hit && !lock[p])
            q <= wdata;
      end

      assign latch[p*PORT_W +: PORT_W] = q;

      AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && lock[p]) |=> $stable(q)); // R3
   end
endmodule

// File: rtl/pdio_sync.sv
module pdio_sync #(
   parameter int WIDTH  = 48,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] st [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '1;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end

      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/pdio_edge_irq.sv
module pdio_edge_irq
   import pdio_pkg::*;
#(
   parameter int NUM_IRQ_PORTS = 3,
   parameter int PORT_W        = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_IRQ_PORTS*PORT_W-1:0] smp,
   input  logic                            bus_wr,
   input  logic [NUM_IRQ_PORTS-1:0]        win_sel,
   input  logic [PORT_W-1:0]               wdata,
   input  pdio_page_e                      page,
   output logic [NUM_IRQ_PORTS*PORT_W-1:0] id,
   output logic [NUM_IRQ_PORTS-1:0]        pend
);
   localparam int CH = NUM_IRQ_PORTS * PORT_W;

   logic [CH-1:0] prev_q, pol_q, en_q, id_q, hit;
   logic          any_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= smp;
   end

   assign hit = en_q & ((pol_q & smp & ~prev_q) | (~pol_q & ~smp & prev_q));

   for (genvar g = 0; g < NUM_IRQ_PORTS; g++) begin : g_bank
      logic [PORT_W-1:0] pol_r, en_r, id_r;
      logic              we;

      assign we = bus_wr && win_sel[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pol_r <= '0;
            en_r  <= '0;
            id_r  <= '0;
         end else begin
            if (we && page == PG_POL) pol_r <= wdata;
            if (we && page == PG_ENA) en_r  <= wdata;
            id_r <= ((we && page == PG_ID) ? (id_r & wdata) : id_r)
                    | hit[g*PORT_W +: PORT_W];
         end
      end

      assign pol_q[g*PORT_W +: PORT_W] = pol_r;
      assign en_q[g*PORT_W +: PORT_W]  = en_r;
      assign id_q[g*PORT_W +: PORT_W]  = id_r;
      assign pend[g] = |id_r;
   end

   assign id      = id_q;
   assign any_clr = bus_wr && (|win_sel) && (page == PG_ID);

   AST_ID_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((id_q & ~$past(id_q) & ~$past(hit)) == '0)); // R7
   AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !any_clr |=> (($past(id_q) & ~id_q) == '0)); // R7
   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(hit) & ~id_q) == '0)); // R8
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((id_q & ~$past(id_q) & ~$past(en_q)) == '0)); // R6
   AST_PAGE0_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && page == PG_OFF) |=> ($stable(pol_q) && $stable(en_q))); // R5
endmodule

// File: rtl/pdio_edge_ctl.sv
module pdio_edge_ctl
   import pdio_pkg::*;
#(
   parameter int NUM_PORTS     = 6,
   parameter int PORT_W        = 8,
   parameter int NUM_IRQ_PORTS = 3,
   parameter int ADDR_W        = 4,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_wr,
   input  logic [PORT_W-1:0]           bus_wdata,
   output logic [PORT_W-1:0]           bus_rdata,
   input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
   output logic [NUM_PORTS*PORT_W-1:0] pin_out,
   output logic                        irq
);
   localparam int NCH       = NUM_PORTS * PORT_W;
   localparam int IRQ_CH    = NUM_IRQ_PORTS * PORT_W;
   localparam int PEND_ADDR = NUM_PORTS;
   localparam int CTRL_ADDR = NUM_PORTS + 1;
   localparam int WIN_ADDR  = NUM_PORTS + 2;

   initial begin
      AST_CFG_WINDOW: assert (WIN_ADDR + NUM_IRQ_PORTS <= (1 << ADDR_W)) else $error("window exceeds address space"); // R4
      AST_CFG_LOCK: assert (NUM_PORTS <= PORT_W - PAGE_BITS) else $error("lock mask overlaps page field"); // R3
      AST_CFG_IRQ: assert (NUM_IRQ_PORTS <= NUM_PORTS && NUM_IRQ_PORTS <= PORT_W) else $error("bad interrupt port count"); // R10
   end

   pdio_page_e               page;
   logic [NUM_PORTS-1:0]     lock;
   logic [NCH-1:0]           smp;
   logic [IRQ_CH-1:0]        id;
   logic [NUM_IRQ_PORTS-1:0] pend;
   logic [NUM_IRQ_PORTS-1:0] win_sel;
   logic                     ctl_we;

   assign ctl_we = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

   for (genvar i = 0; i < NUM_IRQ_PORTS; i++) begin : g_win
      assign win_sel[i] = (bus_addr == ADDR_W'(WIN_ADDR + i));
   end

   pdio_ctl_reg #(.NUM_PORTS(NUM_PORTS), .DATA_W(PORT_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wdata(bus_wdata),
      .page(page), .lock(lock)
   );

   pdio_port_latch #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .wdata(bus_wdata), .lock(lock), .latch(pin_out)
   );

   pdio_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp)
   );

   pdio_edge_irq #(.NUM_IRQ_PORTS(NUM_IRQ_PORTS), .PORT_W(PORT_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .smp(smp[IRQ_CH-1:0]), .bus_wr(bus_wr),
      .win_sel(win_sel), .wdata(bus_wdata), .page(page), .id(id), .pend(pend)
   );

   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++)
         if (bus_addr == ADDR_W'(p)) bus_rdata = smp[p*PORT_W +: PORT_W];
      if (bus_addr == ADDR_W'(PEND_ADDR)) bus_rdata = PORT_W'(pend);
      if (page == PG_ID)
         for (int i = 0; i < NUM_IRQ_PORTS; i++)
            if (bus_addr == ADDR_W'(WIN_ADDR + i)) bus_rdata = id[i*PORT_W +: PORT_W];
   end

   assign irq = |pend;
endmodule

// File: tb/pdio_edge_ctl_tb.sv
`timescale 1ns/1ps
module pdio_edge_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] pin_in, pin_out, ext;
   logic        irq;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   assign pin_in = pin_out & ext;

   pdio_edge_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .irq(irq)
   );

   task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int p = 0; p < 6; p++) begin
         rd(4'(p), d); check("R1 port read after reset", 48'(d), 48'hFF);
      end
      check("R1 pin_out after reset", pin_out, 48'hFFFF_FFFF_FFFF);
      check("R1 irq after reset", 48'(irq), 48'h0);
      rd(4'h6, d); check("R1 pending after reset", 48'(d), 48'h0);
      wr(4'h7, 8'hC0);
      rd(4'h8, d); check("R1 id0 after reset", 48'(d), 48'h0);
      wr(4'h7, 8'h00);
   endtask

   task automatic t_ports();
      logic [7:0] d;
      wr(4'h1, 8'h5A);
      check("R2 pin_out follows latch", 48'(pin_out[15:8]), 48'h5A);
      @(negedge clk);
      rd(4'h1, d); check("R2 read one edge after write still old", 48'(d), 48'hFF);
      @(negedge clk);
      rd(4'h1, d); check("R2 read two edges after write", 48'(d), 48'h5A);
      ext[39:32] = 8'h0F;
      settle();
      rd(4'h4, d); check("R2 external input seen on released port", 48'(d), 48'h0F);
      ext[39:32] = 8'hFF;
      wr(4'h1, 8'hFF);
      settle();
   endtask

   task automatic t_lock();
      logic [7:0] d;
      wr(4'h7, 8'h04);
      wr(4'h2, 8'h00);
      wr(4'h0, 8'hA5);
      settle();
      check("R3 locked latch unchanged", 48'(pin_out[23:16]), 48'hFF);
      rd(4'h2, d); check("R3 locked port read", 48'(d), 48'hFF);
      rd(4'h0, d); check("R3 unlocked port written", 48'(d), 48'hA5);
      wr(4'h7, 8'h00);
      wr(4'h0, 8'hFF);
      settle();
   endtask

   task automatic t_wo_zero();
      logic [7:0] d;
      rd(4'h7, d); check("R4 control reads zero", 48'(d), 48'h0);
      wr(4'h7, 8'h40);
      rd(4'h8, d); check("R4 polarity page reads zero", 48'(d), 48'h0);
      wr(4'h7, 8'h80);
      rd(4'h9, d); check("R4 enable page reads zero", 48'(d), 48'h0);
      wr(4'h7, 8'hC0);
      for (int a = 11; a < 16; a++) begin
         wr(4'(a), 8'hFF);
         rd(4'(a), d); check("R11 unused address reads zero", 48'(d), 48'h0);
      end
      check("R11 unused writes leave latches", pin_out, 48'hFFFF_FFFF_FFFF);
      wr(4'h7, 8'h00);
   endtask

   task automatic t_edges();
      logic [7:0] d;
      wr(4'h7, 8'h40); wr(4'h8, 8'h0F);
      wr(4'h7, 8'h80); wr(4'h8, 8'hFF); wr(4'hA, 8'h80);
      wr(4'h7, 8'hC0);
      ext[0] = 1'b0; settle();
      rd(4'h8, d); check("R6 falling edge ignored on rising channel", 48'(d), 48'h0);
      ext[0] = 1'b1; settle();
      rd(4'h8, d); check("R6 rising edge latched", 48'(d), 48'h01);
      ext[4] = 1'b0; settle();
      rd(4'h8, d); check("R6 falling edge latched", 48'(d), 48'h11);
      rd(4'h6, d); check("R9 pending bit 0", 48'(d), 48'h01);
      check("R9 irq high", 48'(irq), 48'h1);
      ext[8] = 1'b0; settle(); ext[8] = 1'b1; settle();
      rd(4'h9, d); check("R6 disabled channel latches nothing", 48'(d), 48'h0);
      ext[23] = 1'b0; settle();
      rd(4'hA, d); check("R6 port2 falling edge", 48'(d), 48'h80);
      rd(4'h6, d); check("R9 pending bits 0 and 2", 48'(d), 48'h05);
   endtask

   task automatic t_clear();
      logic [7:0] d;
      wr(4'h8, 8'hFE); settle();
      rd(4'h8, d); check("R7 clear of bit 0 only", 48'(d), 48'h10);
      wr(4'h8, 8'hFF); settle();
      rd(4'h8, d); check("R7 writing ones keeps bits", 48'(d), 48'h10);
      wr(4'h8, 8'h00); wr(4'hA, 8'h00); settle();
      rd(4'h8, d); check("R7 clear all", 48'(d), 48'h0);
      rd(4'h6, d); check("R9 pending cleared", 48'(d), 48'h0);
      check("R9 irq low after clear", 48'(irq), 48'h0);
   endtask

   task automatic t_race();
      logic [7:0] d;
      ext[1] = 1'b0; settle();
      ext[1] = 1'b1; settle();
      rd(4'h8, d); check("R7 bit 1 latched", 48'(d), 48'h02);
      ext[1] = 1'b0; settle();
      ext[1] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(4'h8, 8'h00);
      settle();
      rd(4'h8, d); check("R8 edge wins over same-cycle clear", 48'(d), 48'h02);
      wr(4'h8, 8'h00); settle();
      rd(4'h8, d); check("R8 later clear succeeds", 48'(d), 48'h0);
   endtask

   task automatic t_page0();
      logic [7:0] d;
      wr(4'h7, 8'h00);
      wr(4'h9, 8'hFF);
      rd(4'h9, d); check("R5 page 0 window reads zero", 48'(d), 48'h0);
      wr(4'h7, 8'hC0);
      ext[8] = 1'b0; settle(); ext[8] = 1'b1; settle();
      rd(4'h9, d); check("R5 page 0 write did not enable", 48'(d), 48'h0);
      check("R5 irq stays low", 48'(irq), 48'h0);
   endtask

   task automatic t_upper_ports();
      logic [7:0] d;
      ext[47:24] = '0; settle();
      ext[47:24] = '1; settle();
      check("R10 upper ports do not raise irq", 48'(irq), 48'h0);
      rd(4'h6, d); check("R10 pending unaffected by upper ports", 48'(d), 48'h0);
   endtask

   initial begin
      ext = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ports();
      t_lock();
      t_wo_zero();
      t_edges();
      t_clear();
      t_race();
      t_page0();
      t_upper_ports();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1ms;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule